// File: doc/BRIEF.md
# Maskable Latching Transmit-Fault Output

This block drives the transmit-fault output of an optical-module controller. It gathers three kinds of alarm source: a vector of converter limit alarms, a vector of quick-trip alarms and a single laser-driver shutdown alarm. Each source has its own enable bit, and a set bit lets that alarm reach the output. Alarms that are disabled are dropped before anything else happens. The alarm comparators and the register file sit outside the block. The enable bits, the latch-mode bit and the clear pulse arrive here as plain inputs.

The block has two modes. In follow mode the fault output is high only while an enabled converter or quick-trip alarm is present. In hold mode an enabled alarm seen at a clock edge keeps the output high until something clears it: a one-cycle clear pulse, transmit disable (from the pin or the software bit), or loss of supply. An enabled shutdown alarm always sticks, in either mode. Only transmit disable or loss of supply releases it; the clear pulse does not. While the supply is below threshold the output is forced high. While transmit disable is active with a good supply the output is forced low.

Top module: `txf_fault_out`

## Requirements
- R1: While `supply_ok` is 0 the output `tx_fault` is 1, whatever the other inputs are.
- R2: While `supply_ok` is 1 and either `txdis_pin` or `txdis_sw` is 1, `tx_fault` is 0.
- R3: An alarm bit whose enable bit is 0 has no effect on `tx_fault`. Enable bit value 1 means the alarm is enabled, and bit i of each enable vector gates bit i of its alarm vector. With supply good, transmit enabled, nothing held and no enabled alarm active, `tx_fault` is 0.
- R4: With `hold_en` at 0, `tx_fault` goes to 1 in the same cycle that any enabled converter or quick-trip alarm is 1, and returns to 0 in the first cycle it is gone.
- R5: With `hold_en` at 1, an enabled converter or quick-trip alarm present at a rising clock edge keeps `tx_fault` at 1 in the following cycles, after the alarm has gone, until a clear source acts.
- R6: A `fault_clr` pulse sampled at a clock edge releases the held converter/quick-trip fault. From the next cycle `tx_fault` is 0 if no enabled alarm is active and no shutdown is held.
- R7: If an enabled alarm is still active at the edge after a clear, the hold sets again. `tx_fault` then stays 1 after the alarm goes away.
- R8: An enabled shutdown alarm raises `tx_fault` in the same cycle and holds it whatever `hold_en` is. `fault_clr` does not release it.
- R9: Transmit disable (pin or software bit) sampled at an edge releases both the held fault and the held shutdown. After it is removed, `tx_fault` is 0 when no enabled alarm is active.
- R10: A low `supply_ok` sampled at an edge releases all held state, the same as a power cycle. After the supply returns, `tx_fault` is 0 when no enabled alarm is active.
- R11: With `shdn_en` at 0 the shutdown alarm neither raises nor holds `tx_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears held state |
| supply_ok | input | 1 | Supply above power-on threshold |
| conv_alarm | input | N_CONV | Converter limit alarm flags |
| conv_en | input | N_CONV | Converter alarm enables, 1 = enabled |
| qt_alarm | input | N_QT | Quick-trip alarm flags |
| qt_en | input | N_QT | Quick-trip alarm enables, 1 = enabled |
| shdn_alarm | input | 1 | Laser-driver shutdown alarm |
| shdn_en | input | 1 | Shutdown alarm enable, 1 = enabled |
| hold_en | input | 1 | 1 = hold mode, 0 = follow mode |
| fault_clr | input | 1 | One-cycle clear pulse for the held fault |
| txdis_pin | input | 1 | Transmit-disable pin |
| txdis_sw | input | 1 | Software transmit-disable bit |
| tx_fault | output | 1 | Transmit-fault output |

## Verification
The bench goes after the clear ordering. A design that lets the clear pulse reach the shutdown hold would drop `tx_fault` after a clear while shutdown is still in force. A design that gives the clear priority for good would fail to set the hold again while the alarm is still present at the edge after a clear. Supply loss and transmit disable are each checked after their removal. A design that only masks the output during those conditions, and does not release the held state, would bring the fault back when the supply returns or the disable is removed. Enable bits are toggled one at a time with their alarms active. This exposes an inverted enable polarity or a mismatched bit position.

// File: rtl/txf_pkg.sv
package txf_pkg;

  // Output level as the supply, disable and fault state decide it.
  function automatic logic fault_level(input logic supply_good,
                                       input logic tx_disabled,
                                       input logic any_fault);
    if (!supply_good)      return 1'b1;
    else if (tx_disabled)  return 1'b0;
    else                   return any_fault;
  endfunction

  // Next value of a held flag: a release wins over a set.
  function automatic logic hold_next(input logic cur,
                                     input logic release_now,
                                     input logic set_now);
    if (release_now)  return 1'b0;
    else if (set_now) return 1'b1;
    else              return cur;
  endfunction

endpackage

// File: rtl/txf_alarm_gate.sv
module txf_alarm_gate #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] alarm,
  input  logic [WIDTH-1:0] enable,
  output logic             any_active
);
  logic [WIDTH-1:0] gated;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign gated[i] = alarm[i] & enable[i];
  end

  assign any_active = |gated;
endmodule

// File: rtl/txf_hold_flag.sv
module txf_hold_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic release_now,
  input  logic set_now,
  output logic q
);
  import txf_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= hold_next(q, release_now, set_now);
  end
endmodule

// File: rtl/txf_fault_out.sv
module txf_fault_out #(
  parameter int N_CONV = 4,
  parameter int N_QT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic [N_CONV-1:0] conv_alarm,
  input  logic [N_CONV-1:0] conv_en,
  input  logic [N_QT-1:0]   qt_alarm,
  input  logic [N_QT-1:0]   qt_en,
  input  logic              shdn_alarm,
  input  logic              shdn_en,
  input  logic              hold_en,
  input  logic              fault_clr,
  input  logic              txdis_pin,
  input  logic              txdis_sw,
  output logic              tx_fault
);
  import txf_pkg::*;

  // Named internal events, also seen by the bound checker.
  logic conv_any;
  logic qt_any;
  logic live_any;
  logic shdn_live;
  logic txdis_any;
  logic hold_release;
  logic shdn_release;
  logic hold_q;
  logic shdn_q;

  txf_alarm_gate #(.WIDTH(N_CONV)) u_conv_gate (
    .alarm      (conv_alarm),
    .enable     (conv_en),
    .any_active (conv_any)
  );

  txf_alarm_gate #(.WIDTH(N_QT)) u_qt_gate (
    .alarm      (qt_alarm),
    .enable     (qt_en),
    .any_active (qt_any)
  );

  assign live_any     = conv_any | qt_any;
  assign shdn_live    = shdn_alarm & shdn_en;
  assign txdis_any    = txdis_pin | txdis_sw;
  assign shdn_release = !supply_ok | txdis_any;
  assign hold_release = shdn_release | fault_clr;

  txf_hold_flag u_fault_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .release_now (hold_release),
    .set_now     (hold_en & live_any),
    .q           (hold_q)
  );

  txf_hold_flag u_shdn_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .release_now (shdn_release),
    .set_now     (shdn_live),
    .q           (shdn_q)
  );

  assign tx_fault = fault_level(supply_ok, txdis_any,
                                live_any | shdn_live | hold_q | shdn_q);
endmodule

// File: rtl/txf_fault_chk.sv
module txf_fault_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic shdn_alarm,
  input logic shdn_en,
  input logic hold_en,
  input logic fault_clr,
  input logic txdis_pin,
  input logic txdis_sw,
  input logic live_any,
  input logic hold_q,
  input logic shdn_q,
  input logic tx_fault
);
  AST_SUPPLY_LOW_FORCES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> tx_fault); // R1

  AST_DISABLE_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && (txdis_pin || txdis_sw)) |-> !tx_fault); // R2

  AST_HOLD_KEEPS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !txdis_pin && !txdis_sw && !fault_clr && hold_en && live_any)
    |=> (tx_fault || !supply_ok || txdis_pin || txdis_sw)); // R5

  AST_CLEAR_RELEASES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fault_clr |=> !hold_q); // R6

  AST_SHDN_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !txdis_pin && !txdis_sw && shdn_alarm && shdn_en)
    |=> (tx_fault || !supply_ok || txdis_pin || txdis_sw)); // R8

  AST_DISABLE_RELEASES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (txdis_pin || txdis_sw || !supply_ok) |=> (!hold_q && !shdn_q)); // R9
endmodule

bind txf_fault_out txf_fault_chk u_txf_fault_chk (.*);

// File: tb/txf_fault_out_bench.sv
module txf_fault_out_bench;
  localparam int NC = 4;
  localparam int NQ = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic [NC-1:0] conv_alarm = '0, conv_en = '0;
  logic [NQ-1:0] qt_alarm = '0, qt_en = '0;
  logic shdn_alarm = 1'b0, shdn_en = 1'b0, hold_en = 1'b0, fault_clr = 1'b0;
  logic txdis_pin = 1'b0, txdis_sw = 1'b0;
  logic tx_fault;

  int checks = 0;
  int fails = 0;
  logic m_hold = 1'b0;
  logic m_shdn = 1'b0;

  always #5 clk = ~clk;

  txf_fault_out #(.N_CONV(NC), .N_QT(NQ)) u_txf_fault_out (.*);

  function automatic logic b_live();
    logic any;
    any = 1'b0;
    for (int i = 0; i < NC; i++) any = any | (conv_alarm[i] && conv_en[i]);
    for (int i = 0; i < NQ; i++) any = any | (qt_alarm[i] && qt_en[i]);
    return any;
  endfunction

  function automatic logic b_expect();
    if (supply_ok == 1'b0) return 1'b1;
    if (txdis_pin || txdis_sw) return 1'b0;
    return b_live() || (shdn_alarm && shdn_en) || m_hold || m_shdn;
  endfunction

  task automatic check(input string tag, input logic exp);
    checks++;
    if (tx_fault !== exp) begin
      fails++;
      $display("FAIL %s: tx_fault=%b expected=%b at %0t", tag, tx_fault, exp, $time);
    end
  endtask

  // Inputs already set after a negedge: check, then advance past posedge and update the model.
  task automatic step(input string tag);
    logic rel;
    #1;
    check(tag, b_expect());
    @(posedge clk);
    rel = !supply_ok || txdis_pin || txdis_sw;
    if (rel || fault_clr) m_hold = 1'b0;
    else if (hold_en && b_live()) m_hold = 1'b1;
    if (rel) m_shdn = 1'b0;
    else if (shdn_alarm && shdn_en) m_shdn = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
  endtask

  task automatic idle();
    conv_alarm = '0; qt_alarm = '0; shdn_alarm = 1'b0;
    txdis_pin = 1'b0; txdis_sw = 1'b0; fault_clr = 1'b0; supply_ok = 1'b1;
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1875));
    @(negedge clk);
    #1; check("R1 reset", 1'b1);
    supply_ok = 1'b1;
    #1; check("R3 reset", 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R3: alarms with their enables off, then the enables one at a time
    conv_alarm = '1; qt_alarm = '1; step("R3 masked");
    conv_en = 4'b0100; step("R4 conv bit2");
    conv_en = '0; qt_en = 2'b10; step("R4 qt bit1");
    qt_alarm = 2'b01; step("R3 qt bit0 masked");
    idle(); conv_en = '1; qt_en = '1; step("R4 drop");

    // R5/R6 hold and clear
    hold_en = 1'b1; conv_alarm = 4'b0001; step("R5 set");
    conv_alarm = '0; step("R5 held");
    step("R5 held2");
    fault_clr = 1'b1; step("R6 clr cycle");
    step("R6 released");

    // R7: alarm still present across the clear
    qt_alarm = 2'b01; step("R7 alarm");
    fault_clr = 1'b1; step("R7 clr");
    step("R7 reset again");
    qt_alarm = '0; step("R7 held");
    fault_clr = 1'b1; step("R7 clr2");
    step("R6 after R7");

    // R8: shutdown sticks, clear does not release it, follow mode too
    hold_en = 1'b0; shdn_en = 1'b1; shdn_alarm = 1'b1; step("R8 raise");
    shdn_alarm = 1'b0; step("R8 held");
    fault_clr = 1'b1; step("R8 clr");
    step("R8 clr ignored");
    // R9: software disable releases it
    txdis_sw = 1'b1; step("R2 sw");
    txdis_sw = 1'b0; step("R9 released");
    // R9: pin releases held fault in hold mode
    hold_en = 1'b1; conv_alarm = 4'b1000; shdn_alarm = 1'b1; step("R9 set");
    idle(); txdis_pin = 1'b1; step("R2 pin");
    txdis_pin = 1'b0; step("R9 pin released");
    // R10: supply loss releases everything
    shdn_alarm = 1'b1; conv_alarm = 4'b0010; step("R10 set");
    idle(); supply_ok = 1'b0; step("R1 low");
    supply_ok = 1'b1; step("R10 released");
    // R11: shutdown disabled
    shdn_en = 1'b0; shdn_alarm = 1'b1; step("R11 raise");
    shdn_alarm = 1'b0; step("R11 hold");

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      r = $urandom();
      conv_alarm = NC'($urandom()); qt_alarm = NQ'($urandom());
      if (r[3:0] == 0) begin conv_en = NC'($urandom()); qt_en = NQ'($urandom()); end
      shdn_alarm = (r[8:4] == 0);
      shdn_en = r[9];
      if (r[13:10] == 0) hold_en = ~hold_en;
      fault_clr = (r[17:14] == 0);
      txdis_pin = (r[22:18] == 0);
      txdis_sw = (r[27:23] == 0);
      supply_ok = (r[31:28] != 0);
      if (r[5:4] == 0) begin conv_alarm = '0; qt_alarm = '0; end
      if (!supply_ok) step("R1 rand");
      else if (txdis_pin || txdis_sw) step("R2 rand");
      else step("R4 rand");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule